// File: doc/BRIEF.md
# Chained counter-timer, upper word

This block is the upper 32 bits of a 64-bit counter-timer that is built from two 32-bit units. The lower unit is a separate block. It drives a carry strobe one clock before its own wrap, and this block advances by one only on a clock where that strobe is high. When the upper word sits at its terminal value, the block raises a registered stop flag. The lower unit uses that flag to decide when the pair as a whole stops or reloads.

Software sets up the block through three registers, and each has a write enable.
- The configuration register holds five bits: enable, oneshot, direction, chain and interrupt enable.
- The reload register sets the terminal value for up counting and the start value for down counting. It has one write enable per byte lane.
- The current-value register can be read and overwritten. It also has one write enable per byte lane.

When the lower unit counts up with a stop value of zero, both halves wrap on the same clock. In that case the lower unit raises an offset hint, and this block moves its terminal compare one step earlier. The interrupt output is the stop flag delayed by one clock and gated by the interrupt enable bit.

Top module: `hiword_timer`

## Requirements
- R1: The configuration write takes enable at bit 0, oneshot at bit 1, direction at bit 2 (1 = up), chain at bit 3 and interrupt enable at bit 4. A read returns these five bits and zeros above bit 4.
- R2: The reload register is written per byte lane: lane k covers bits 8k+7..8k. Lanes whose enable is low keep their value. The register is readable at all times.
- R3: On the first clock where the effective enable is high after a clock where it was low, the current value loads the start value and the stop flag clears. The start value is zero when counting up and the reload value when counting down.
- R4: While enabled and not being written, the current value changes only on a clock where the carry strobe is high.
- R5: Counting down, each strobe decrements the value, and the terminal value is zero. The stop flag is high after the step that brings the value to the terminal value.
- R6: Counting up, each strobe increments the value. The terminal value is the reload value, or the reload value minus one when the offset hint is high.
- R7: On a strobe while already at the terminal value:
  - in oneshot mode the value holds and the stop flag stays high;
  - in continuous mode the value reloads the start value and the stop flag clears.
- R8: While enabled, the interrupt output equals the previous clock's stop flag ANDed with the interrupt enable bit. While disabled, the interrupt output is low.
- R9: A write to the current-value register on any byte lane replaces the selected bytes, keeps the others and clears the stop flag. It takes priority over counting on that clock.
- R10: The enable output reflects the configured enable bit. With chain set, the effective enable is the configured enable ANDed with the enable input.
- R11: An active-low asynchronous reset clears configuration, reload, current value, stop flag and interrupt without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback |
| reload_we | input | 4 | Reload register byte-lane write enables |
| reload_wdata | input | 32 | Reload register write data |
| reload_rdata | output | 32 | Reload register readback |
| cur_we | input | 4 | Current-value byte-lane write enables |
| cur_wdata | input | 32 | Current-value write data |
| cur_rdata | output | 32 | Current value |
| carry_strobe_i | input | 1 | Early carry strobe from the lower unit |
| offset_i | input | 1 | Offset hint from the lower unit |
| enable_i | input | 1 | Enable from the partner unit, used when chained |
| enable_o | output | 1 | Configured enable, sent to the partner |
| stop_o | output | 1 | Upper word at terminal value |
| irq_o | output | 1 | Gated, delayed stop flag |

## Verification
A wrong start value or a wrong step direction shows on the current-value port one clock after the enable edge or after the strobe that caused it. A wrong terminal compare shows as a stop flag that rises one strobe too early or too late, and most visibly under the offset hint. A lost previous-enable bit shows as a missing reload on the enable edge. A broken interrupt delay shows one clock after the stop flag changes.

// File: rtl/hiword_timer_pkg.sv
package hiword_timer_pkg;
    localparam int CFG_W = 5;

    typedef struct packed {
        logic irq_ena;
        logic chain;
        logic up;
        logic oneshot;
        logic en;
    } cfg_t;
endpackage

// File: rtl/hiword_cfg_regs.sv
module hiword_cfg_regs
    import hiword_timer_pkg::*;
#(
    parameter int W = 32,
    localparam int NB = W / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [NB-1:0] reload_we,
    input  logic [W-1:0]  reload_wdata,
    output cfg_t          cfg_o,
    output logic [W-1:0]  reload_o
);
    typedef struct packed {
        cfg_t         cfg;
        logic [W-1:0] reload;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (cfg_we) regs_d.cfg = cfg_t'(cfg_wdata);
        for (int b = 0; b < NB; b++) begin
            if (reload_we[b]) regs_d.reload[b*8 +: 8] = reload_wdata[b*8 +: 8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign cfg_o    = regs_q.cfg;
    assign reload_o = regs_q.reload;

    AST_CFG_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_o == $past(cfg_wdata)); // R1
    AST_RELOAD_LANE0_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !reload_we[0] |=> $stable(reload_o[7:0])); // R2
endmodule

// File: rtl/hiword_count_core.sv
module hiword_count_core
    import hiword_timer_pkg::*;
#(
    parameter int W = 32,
    localparam int NB = W / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cfg_t          cfg,
    input  logic [W-1:0]  reload,
    input  logic [NB-1:0] cur_we,
    input  logic [W-1:0]  cur_wdata,
    input  logic          strobe,
    input  logic          offset,
    input  logic          enable_in,
    output logic [W-1:0]  cur_o,
    output logic          stop_o,
    output logic          irq_o
);
    typedef struct packed {
        logic [W-1:0] cur;
        logic         stop;
        logic         irq;
        logic         last_en;
    } state_t;

    state_t st_d, st_q;

    logic         eff_en;
    logic         cur_write;
    logic [W-1:0] merged;
    logic [W-1:0] term;
    logic [W-1:0] start;
    logic [W-1:0] stepped;

    always_comb begin
        eff_en    = cfg.chain ? (cfg.en & enable_in) : cfg.en;
        cur_write = |cur_we;
        merged    = st_q.cur;
        for (int b = 0; b < NB; b++) begin
            if (cur_we[b]) merged[b*8 +: 8] = cur_wdata[b*8 +: 8];
        end
        term    = cfg.up ? (offset ? reload - W'(1) : reload) : '0;
        start   = cfg.up ? '0 : reload;
        stepped = cfg.up ? st_q.cur + W'(1) : st_q.cur - W'(1);

        st_d         = st_q;
        st_d.last_en = eff_en;
        if (cur_write) begin
            st_d.cur  = merged;
            st_d.stop = 1'b0;
        end else if (eff_en) begin
            st_d.irq = cfg.irq_ena & st_q.stop;
            if (!st_q.last_en) begin
                st_d.cur  = start;
                st_d.stop = 1'b0;
            end else if (strobe) begin
                if (st_q.cur == term) begin
                    if (cfg.oneshot) begin
                        st_d.stop = 1'b1;
                    end else begin
                        st_d.cur  = start;
                        st_d.stop = 1'b0;
                    end
                end else begin
                    st_d.cur  = stepped;
                    st_d.stop = (stepped == term);
                end
            end
        end else begin
            st_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_o  = st_q.cur;
    assign stop_o = st_q.stop;
    assign irq_o  = st_q.irq;

    AST_START_UP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_en && !st_q.last_en && !cur_write && cfg.up) |=> (cur_o == '0 && !stop_o)); // R3
    AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_en && st_q.last_en && !strobe && !cur_write) |=> $stable(cur_o)); // R4
    AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_en && st_q.last_en && !cur_write && cfg.oneshot && stop_o && cur_o == term)
        |=> ($stable(cur_o) && stop_o)); // R7
    AST_IRQ_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_en && !cur_write) |=> irq_o == $past(cfg.irq_ena && stop_o)); // R8
    AST_WRITE_CLEARS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        cur_write |=> !stop_o); // R9
    AST_DISABLED_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!eff_en && !cur_write) |=> !irq_o); // R8
endmodule

// File: rtl/hiword_timer.sv
module hiword_timer
    import hiword_timer_pkg::*;
#(
    parameter int W = 32,
    localparam int NB = W / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [W-1:0]  cfg_rdata,
    input  logic [NB-1:0] reload_we,
    input  logic [W-1:0]  reload_wdata,
    output logic [W-1:0]  reload_rdata,
    input  logic [NB-1:0] cur_we,
    input  logic [W-1:0]  cur_wdata,
    output logic [W-1:0]  cur_rdata,
    input  logic          carry_strobe_i,
    input  logic          offset_i,
    input  logic          enable_i,
    output logic          enable_o,
    output logic          stop_o,
    output logic          irq_o
);
    cfg_t cfg;

    hiword_cfg_regs #(.W(W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .reload_we    (reload_we),
        .reload_wdata (reload_wdata),
        .cfg_o        (cfg),
        .reload_o     (reload_rdata)
    );

    hiword_count_core #(.W(W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .reload    (reload_rdata),
        .cur_we    (cur_we),
        .cur_wdata (cur_wdata),
        .strobe    (carry_strobe_i),
        .offset    (offset_i),
        .enable_in (enable_i),
        .cur_o     (cur_rdata),
        .stop_o    (stop_o),
        .irq_o     (irq_o)
    );

    assign cfg_rdata = {{(W-CFG_W){1'b0}}, cfg};
    assign enable_o  = cfg.en;

    AST_ENABLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> enable_o == $past(cfg_wdata[0])); // R10
endmodule

// File: tb/hiword_timer_bench.sv
module hiword_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [3:0]  reload_we = '0;
    logic [31:0] reload_wdata = '0;
    logic [31:0] reload_rdata;
    logic [3:0]  cur_we = '0;
    logic [31:0] cur_wdata = '0;
    logic [31:0] cur_rdata;
    logic        carry_strobe_i = 1'b0;
    logic        offset_i = 1'b0;
    logic        enable_i = 1'b0;
    logic        enable_o, stop_o, irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hiword_timer u_hiword_timer (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .reload_we(reload_we), .reload_wdata(reload_wdata), .reload_rdata(reload_rdata),
        .cur_we(cur_we), .cur_wdata(cur_wdata), .cur_rdata(cur_rdata),
        .carry_strobe_i(carry_strobe_i), .offset_i(offset_i), .enable_i(enable_i),
        .enable_o(enable_o), .stop_o(stop_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic write_cfg(input logic [4:0] v);
        cfg_wdata = v; cfg_we = 1'b1; tick(); cfg_we = 1'b0;
    endtask

    task automatic write_reload(input logic [3:0] lanes, input logic [31:0] v);
        reload_wdata = v; reload_we = lanes; tick(); reload_we = '0;
    endtask

    task automatic pulse();
        carry_strobe_i = 1'b1; tick(); carry_strobe_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 cur", cur_rdata, 0);
        chk("R11 stop", {31'd0, stop_o}, 0);
        chk("R11 irq", {31'd0, irq_o}, 0);
        chk("R11 cfg", cfg_rdata, 0);
    endtask

    task automatic t_regs();
        write_cfg(5'h1F);
        chk("R1 readback", cfg_rdata, 32'h1F);
        chk("R10 enable_o", {31'd0, enable_o}, 1);
        write_cfg(5'h00);
        chk("R10 enable_o off", {31'd0, enable_o}, 0);
        write_reload(4'hF, 32'hFFFF_FFFF);
        write_reload(4'b0100, 32'h0012_0000);
        chk("R2 lane", reload_rdata, 32'hFF12_FFFF);
    endtask

    task automatic t_down_continuous();
        write_reload(4'hF, 32'd3);
        write_cfg(5'h11);
        tick();
        chk("R3 down start", cur_rdata, 3);
        chk("R3 stop clear", {31'd0, stop_o}, 0);
        tick(); tick();
        chk("R4 no strobe hold", cur_rdata, 3);
        pulse();
        chk("R5 dec", cur_rdata, 2);
        pulse(); pulse();
        chk("R5 at zero", cur_rdata, 0);
        chk("R5 stop", {31'd0, stop_o}, 1);
        chk("R8 irq lag", {31'd0, irq_o}, 0);
        tick();
        chk("R8 irq", {31'd0, irq_o}, 1);
        pulse();
        chk("R7 continuous reload", cur_rdata, 3);
        chk("R7 stop cleared", {31'd0, stop_o}, 0);
        tick();
        chk("R8 irq falls", {31'd0, irq_o}, 0);
        write_cfg(5'h00);
        tick();
        chk("R8 disabled irq", {31'd0, irq_o}, 0);
    endtask

    task automatic t_up_offset();
        write_reload(4'hF, 32'd2);
        offset_i = 1'b1;
        write_cfg(5'h07);
        tick();
        chk("R3 up start", cur_rdata, 0);
        pulse();
        chk("R6 offset early stop", {31'd0, stop_o}, 1);
        chk("R6 offset value", cur_rdata, 1);
        pulse();
        chk("R7 oneshot hold", cur_rdata, 1);
        chk("R7 oneshot stop", {31'd0, stop_o}, 1);
        chk("R8 gated irq", {31'd0, irq_o}, 0);
        write_cfg(5'h00);
        offset_i = 1'b0;
        write_cfg(5'h07);
        tick();
        pulse();
        chk("R6 no offset no stop", {31'd0, stop_o}, 0);
        pulse();
        chk("R6 terminal reload", cur_rdata, 2);
        chk("R6 stop", {31'd0, stop_o}, 1);
    endtask

    task automatic t_write_prio();
        cur_wdata = 32'hAABB_CC55; cur_we = 4'b0001; carry_strobe_i = 1'b1;
        tick();
        cur_we = '0; carry_strobe_i = 1'b0;
        chk("R9 lane write", cur_rdata, 32'h0000_0055);
        chk("R9 stop clear", {31'd0, stop_o}, 0);
        pulse();
        chk("R9 counts after", cur_rdata, 32'h56);
    endtask

    task automatic t_chain();
        write_cfg(5'h00);
        enable_i = 1'b0;
        write_cfg(5'h0D);
        chk("R10 enable_o chained", {31'd0, enable_o}, 1);
        pulse();
        chk("R10 gated no step", cur_rdata, 32'h56);
        enable_i = 1'b1;
        tick();
        chk("R10 start on enable_i", cur_rdata, 0);
        pulse();
        chk("R10 steps", cur_rdata, 1);
    endtask

    task automatic t_async_reset();
        #1 rst_n = 1'b0;
        #1;
        chk("R11 async cur", cur_rdata, 0);
        chk("R11 async cfg", cfg_rdata, 0);
        chk("R11 async reload", reload_rdata, 0);
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    initial begin
        tick(); tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_regs();
        t_down_continuous();
        t_up_offset();
        t_write_prio();
        t_chain();
        t_async_reset();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule